// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block takes serial characters from a single input line and holds the most recent one in a one-deep buffer for a host to read. Software settings choose the number of data bits (five to nine), the parity check (none, even or odd) and the timing mode. In asynchronous mode the line is oversampled against an externally supplied tick. In synchronous mode the data is taken on one edge of an external serial clock, and a polarity setting picks which edge.

Each finished character raises a completion flag and, when enabled, an interrupt request. The host reads the character through the data and ninth-bit outputs. It then pulses a read strobe, which frees the buffer. The buffered character carries frame-error and parity-error flags, and an overrun flag records a lost character. Clearing the enable flushes the buffer and all flags. The line and the serial clock are resynchronised inside the block, so both may be fully asynchronous to `clk`.

Top module: `cfg_serial_rx`

## Requirements
- R1: In asynchronous mode (`syncMode`=0) the line is sampled once per `sampleTick`, 16 ticks per bit, least significant data bit first. A completed character sets `rxComplete`.
- R2: `charSize` 000, 001, 010, 011 select 5, 6, 7, 8 data bits and 111 selects 9. The reserved codes 100 to 110 behave as 8 bits. Unused high bits of `rxData` read 0. `rxBit8` carries the ninth bit in 9-bit mode and reads 0 otherwise.
- R3: `parityMode` 00 means no parity bit, 10 means even and 11 means odd. 01 is reserved and behaves as 00. When the received parity bit does not give the selected total parity, `parityErr` is set together with the character.
- R4: Only the first stop bit is checked. If it is sampled low, `frameErr` is set with the character. A new start bit is accepted from the middle of the stop bit onward.
- R5: If a character completes while `rxComplete` is 1 and `dataRead` is not asserted in that cycle, the character is dropped, `overrunErr` is set, and `rxData` and `rxComplete` keep their values.
- R6: A `dataRead` pulse clears `rxComplete` and `overrunErr`. If the read falls in the same cycle as a completion, the new character is accepted and no overrun is flagged.
- R7: While `rxEnable` is 0, the block clears `rxComplete`, all three error flags, `rxData` and `rxBit8` within one cycle, abandons any frame in progress and ignores the line.
- R8: `rxIrq` is 1 exactly when `rxIntEn`, `globalIntEn` and `rxComplete` are all 1.
- R9: In synchronous mode (`syncMode`=1) each bit is taken on the falling edge of `extClk` when `clkPolarity` is 0, and on the rising edge when it is 1. A low sample while idle is the start bit.
- R10: Each asynchronous bit is decided by a 2-of-3 vote of the samples at ticks 7, 8 and 9 of the bit. A one-tick glitch does not change a bit, and a low pulse one tick wide does not start a frame.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receiver enable; 0 flushes the buffer and flags |
| syncMode | input | 1 | 0 asynchronous, 1 synchronous |
| clkPolarity | input | 1 | Synchronous sampling edge: 0 falling, 1 rising |
| charSize | input | 3 | Character size code |
| parityMode | input | 2 | Parity mode code |
| sampleTick | input | 1 | Oversampling tick, 16 per bit |
| extClk | input | 1 | External serial clock for synchronous mode |
| serialIn | input | 1 | Serial data line, idle high |
| dataRead | input | 1 | Read strobe for the buffered character |
| rxIntEn | input | 1 | Receive-complete interrupt enable |
| globalIntEn | input | 1 | Global interrupt enable |
| rxData | output | 8 | Low eight bits of the buffered character |
| rxBit8 | output | 1 | Ninth bit of the buffered character |
| rxComplete | output | 1 | Buffer holds an unread character |
| frameErr | output | 1 | Stop bit of the buffered character was low |
| overrunErr | output | 1 | A character was lost to a full buffer |
| parityErr | output | 1 | Parity mismatch on the buffered character |
| rxIrq | output | 1 | Receive-complete interrupt request |

## Verification
A host read and the completion of a new character can fall in the same clock cycle. That case decides between accepting the character and flagging an overrun. The bench leaves one character unread and sends a second one, with a single-cycle read placed at a different clock offset inside the stop bit on each pass. The sweep spans the decision point. Every offset must end with no overrun, and with either the new character still pending or the old one already consumed. Both outcomes must appear across the sweep.

// File: rtl/cfg_serial_rx_pkg.sv
package cfg_serial_rx_pkg;

  localparam int CHAR_MAX = 9;
  localparam int DATA_W   = CHAR_MAX - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_e;

  // strobes from control to datapath, at most one event per cycle
  typedef struct packed {
    logic startFrame;
    logic dataBit;
    logic parityBit;
    logic stopBit;
    logic bitVal;
  } rxStrobe_t;

  function automatic logic [3:0] charBits(input logic [2:0] code);
    case (code)
      3'b000:  return 4'd5;
      3'b001:  return 4'd6;
      3'b010:  return 4'd7;
      3'b111:  return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/cfg_serial_rx_sync.sv
module cfg_serial_rx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/cfg_serial_rx_ctrl.sv
module cfg_serial_rx_ctrl
  import cfg_serial_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEnable,
  input  logic      syncMode,
  input  logic      sampleTick,
  input  logic      edgeEvt,
  input  logic      lineIn,
  input  logic [3:0] nBits,
  input  logic      parityEn,
  output rxStrobe_t strb
);

  localparam int            PW        = $clog2(OVS);
  localparam logic [PW-1:0] DECIDE_PH = PW'(OVS / 2 + 1);
  localparam logic [PW-1:0] LAST_PH   = PW'(OVS - 1);

  rxState_e      state;
  logic [PW-1:0] phase;
  logic [1:0]    hist;
  logic [3:0]    bitIdx;
  logic          vote, asyncEvt, evt, val, lastData;

  // 2-of-3 vote: two stored samples plus the current one
  assign vote     = (hist[1] & hist[0]) | (hist[1] & lineIn) | (hist[0] & lineIn);
  assign asyncEvt = !syncMode && sampleTick && (state != ST_IDLE) && (phase == DECIDE_PH);
  assign evt      = rxEnable && (syncMode ? edgeEvt : asyncEvt);
  assign val      = syncMode ? lineIn : vote;
  assign lastData = (bitIdx == nBits - 4'd1);

  always_comb begin
    strb            = '0;
    strb.bitVal     = val;
    strb.startFrame = (state == ST_IDLE && rxEnable && syncMode && edgeEvt && !lineIn)
                   || (state == ST_START && evt && !val);
    strb.dataBit    = (state == ST_DATA)   && evt;
    strb.parityBit  = (state == ST_PARITY) && evt;
    strb.stopBit    = (state == ST_STOP)   && evt;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !rxEnable) begin
      state  <= ST_IDLE;
      phase  <= '0;
      hist   <= 2'b11;
      bitIdx <= '0;
    end else begin
      if (!syncMode && sampleTick) hist <= {hist[0], lineIn};
      case (state)
        ST_IDLE: begin
          if (!syncMode && sampleTick && !lineIn) begin
            state <= ST_START;
            phase <= PW'(1);
          end else if (syncMode && edgeEvt && !lineIn) begin
            state  <= ST_DATA;
            bitIdx <= '0;
          end
        end
        default: begin
          if (!syncMode && sampleTick)
            phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
          if (evt) begin
            case (state)
              ST_START: begin
                state  <= val ? ST_IDLE : ST_DATA;
                bitIdx <= '0;
              end
              ST_DATA: begin
                bitIdx <= bitIdx + 4'd1;
                if (lastData) state <= parityEn ? ST_PARITY : ST_STOP;
              end
              ST_PARITY: state <= ST_STOP;
              default:   state <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // checker: async bit events are spaced one full bit of ticks apart
  logic [PW:0] tickGap;
  logic        gapValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickGap  <= '0;
      gapValid <= 1'b0;
    end else begin
      if (evt) tickGap <= '0;
      else if (sampleTick && tickGap != '1) tickGap <= tickGap + 1'b1;
      if (!rxEnable || syncMode || strb.stopBit) gapValid <= 1'b0;
      else if (strb.startFrame) gapValid <= 1'b1;
    end
  end

  a_r1_bit_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && !syncMode && gapValid && (strb.dataBit || strb.parityBit || strb.stopBit))
      |-> (tickGap == (PW+1)'(OVS - 1)));

endmodule

// File: rtl/cfg_serial_rx_dp.sv
module cfg_serial_rx_dp
  import cfg_serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  rxStrobe_t         strb,
  input  logic [3:0]        nBits,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              dataRead,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit8,
  output logic              rxComplete,
  output logic              frameErr,
  output logic              overrunErr,
  output logic              parityErr
);

  localparam logic [3:0] MAXB = 4'(CHAR_MAX);

  logic [CHAR_MAX-1:0] shiftReg;
  logic [CHAR_MAX-1:0] aligned;
  logic                parAcc;
  logic                bufFree;

  // bits enter at the top, so a short character is right-aligned by shifting
  assign aligned = shiftReg >> (MAXB - nBits);
  assign bufFree = !rxComplete || dataRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      parAcc     <= 1'b0;
      rxData     <= '0;
      rxBit8     <= 1'b0;
      rxComplete <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
      parityErr  <= 1'b0;
    end else begin
      if (strb.startFrame) begin
        shiftReg <= '0;
        parAcc   <= 1'b0;
      end else if (strb.dataBit) begin
        shiftReg <= {strb.bitVal, shiftReg[CHAR_MAX-1:1]};
        parAcc   <= parAcc ^ strb.bitVal;
      end else if (strb.parityBit) begin
        parAcc   <= parAcc ^ strb.bitVal;
      end

      if (!rxEnable) begin
        rxData     <= '0;
        rxBit8     <= 1'b0;
        rxComplete <= 1'b0;
        frameErr   <= 1'b0;
        overrunErr <= 1'b0;
        parityErr  <= 1'b0;
      end else if (strb.stopBit) begin
        if (bufFree) begin
          rxData     <= aligned[DATA_W-1:0];
          rxBit8     <= (nBits == MAXB) & aligned[CHAR_MAX-1];
          frameErr   <= !strb.bitVal;
          parityErr  <= parityEn && (parAcc != parityOdd);
          rxComplete <= 1'b1;
          overrunErr <= 1'b0;
        end else begin
          overrunErr <= 1'b1;
        end
      end else if (dataRead) begin
        rxComplete <= 1'b0;
        overrunErr <= 1'b0;
      end
    end
  end

  a_r7_disable_flush: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (!rxComplete && !frameErr && !overrunErr && !parityErr && rxData == '0));

  a_r5_overrun_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && strb.stopBit && rxComplete && !dataRead)
      |=> (overrunErr && rxComplete && $stable(rxData)));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && dataRead && !strb.stopBit) |=> (!rxComplete && !overrunErr));

  a_r4_frame_err: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && strb.stopBit && !strb.bitVal && bufFree) |=> (frameErr && rxComplete));

endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfg_serial_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              syncMode,
  input  logic              clkPolarity,
  input  logic [2:0]        charSize,
  input  logic [1:0]        parityMode,
  input  logic              sampleTick,
  input  logic              extClk,
  input  logic              serialIn,
  input  logic              dataRead,
  input  logic              rxIntEn,
  input  logic              globalIntEn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit8,
  output logic              rxComplete,
  output logic              frameErr,
  output logic              overrunErr,
  output logic              parityErr,
  output logic              rxIrq
);

  logic      lineIn, extSync, extPrev, edgeEvt;
  logic [3:0] nBits;
  rxStrobe_t strb;

  cfg_serial_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) lineSync_i (
    .clk(clk), .rstN(rstN), .din(serialIn), .dout(lineIn));

  cfg_serial_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) clkSync_i (
    .clk(clk), .rstN(rstN), .din(extClk), .dout(extSync));

  always_ff @(posedge clk) begin
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extSync;
  end

  // polarity 0 samples on the falling edge, polarity 1 on the rising edge
  assign edgeEvt = clkPolarity ? (extSync & ~extPrev) : (~extSync & extPrev);
  assign nBits   = charBits(charSize);

  cfg_serial_rx_ctrl #(.OVS(OVS)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .syncMode(syncMode),
    .sampleTick(sampleTick), .edgeEvt(edgeEvt), .lineIn(lineIn),
    .nBits(nBits), .parityEn(parityMode[1]), .strb(strb));

  cfg_serial_rx_dp dp_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .strb(strb), .nBits(nBits),
    .parityEn(parityMode[1]), .parityOdd(parityMode[0]), .dataRead(dataRead),
    .rxData(rxData), .rxBit8(rxBit8), .rxComplete(rxComplete),
    .frameErr(frameErr), .overrunErr(overrunErr), .parityErr(parityErr));

  assign rxIrq = rxIntEn & globalIntEn & rxComplete;

endmodule

// File: tb/cfg_serial_rx_tb_top.sv
module cfg_serial_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int OVS        = 16;
  localparam int BIT_CLKS   = OVS * TICK_DIV;

  logic clk = 1'b0, rstN = 1'b0;
  logic rxEnable = 1'b0, syncMode = 1'b0, clkPolarity = 1'b0;
  logic [2:0] charSize = 3'b011;
  logic [1:0] parityMode = 2'b00;
  logic sampleTick = 1'b0, extClk = 1'b0, serialIn = 1'b1, dataRead = 1'b0;
  logic rxIntEn = 1'b0, globalIntEn = 1'b0;
  logic [7:0] rxData;
  logic rxBit8, rxComplete, frameErr, overrunErr, parityErr, rxIrq;
  logic [1:0] tdiv = 2'd0;

  int testCount = 0, failCount = 0;
  bit finished = 1'b0;

  cfg_serial_rx dut_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .syncMode(syncMode),
    .clkPolarity(clkPolarity), .charSize(charSize), .parityMode(parityMode),
    .sampleTick(sampleTick), .extClk(extClk), .serialIn(serialIn),
    .dataRead(dataRead), .rxIntEn(rxIntEn), .globalIntEn(globalIntEn),
    .rxData(rxData), .rxBit8(rxBit8), .rxComplete(rxComplete),
    .frameErr(frameErr), .overrunErr(overrunErr), .parityErr(parityErr),
    .rxIrq(rxIrq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv       <= tdiv + 2'd1;
    sampleTick <= (tdiv == 2'd3);
  end

  task automatic check(string req, string what, int act, int exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int sizeOf(logic [2:0] code);
    case (code)
      3'b000: return 5;
      3'b001: return 6;
      3'b010: return 7;
      3'b111: return 9;
      default: return 8;
    endcase
  endfunction

  function automatic logic parityOf(logic [8:0] d, int n);
    logic p = 1'b0;
    for (int i = 0; i < n; i++) p ^= d[i];
    return p;
  endfunction

  function automatic logic [8:0] maskChar(logic [8:0] d, int n);
    return d & ((9'h1 << n) - 9'h1);
  endfunction

  task automatic driveBit(logic b, bit glitch, int readAt);
    for (int c = 0; c < BIT_CLKS; c++) begin
      @(negedge clk);
      serialIn = (glitch && c >= 8*TICK_DIV && c < 9*TICK_DIV) ? ~b : b;
      dataRead = (c == readAt);
    end
  endtask

  task automatic sendAsync(logic [8:0] d, int n, logic [1:0] pm, bit badPar,
                           bit badStop, int glitchBit, int readAt);
    driveBit(1'b0, 1'b0, -1);
    for (int i = 0; i < n; i++) driveBit(d[i], i == glitchBit, -1);
    if (pm[1]) driveBit(parityOf(d, n) ^ pm[0] ^ badPar, 1'b0, -1);
    driveBit(!badStop, 1'b0, readAt);
    @(negedge clk);
    serialIn = 1'b1;
    dataRead = 1'b0;
    repeat (2*BIT_CLKS) @(negedge clk);
  endtask

  task automatic syncBit(logic b);
    @(negedge clk) extClk = ~clkPolarity;
    repeat (2) @(negedge clk);
    serialIn = b;
    repeat (2) @(negedge clk);
    extClk = clkPolarity;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendSync(logic [8:0] d, int n, logic [1:0] pm, bit badPar, bit badStop);
    syncBit(1'b0);
    for (int i = 0; i < n; i++) syncBit(d[i]);
    if (pm[1]) syncBit(parityOf(d, n) ^ pm[0] ^ badPar);
    syncBit(!badStop);
    serialIn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic expectChar(logic [8:0] d, int n, bit pe, bit fe);
    logic [8:0] e = maskChar(d, n);
    check("R1", "complete", rxComplete, 1);
    check("R2", "data", rxData, e[7:0]);
    check("R2", "bit8", rxBit8, e[8]);
    check("R3", "parityErr", parityErr, pe);
    check("R4", "frameErr", frameErr, fe);
  endtask

  task automatic readChar();
    @(negedge clk) dataRead = 1'b1;
    @(negedge clk) dataRead = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [2:0] codes [5] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b111};
    int seenNew = 0, seenOld = 0;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11", "rxComplete", rxComplete, 0);
    check("R11", "rxData", rxData, 0);
    check("R11", "flags", {frameErr, overrunErr, parityErr, rxBit8, rxIrq}, 0);
    rstN = 1'b1; rxEnable = 1'b1; rxIntEn = 1'b1; globalIntEn = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);

    // R1 basic async character, R8 interrupt
    sendAsync(9'h0A5, 8, 2'b00, 0, 0, -1, -1);
    expectChar(9'h0A5, 8, 0, 0);
    check("R8", "irq on", rxIrq, 1);
    globalIntEn = 1'b0; #1;
    check("R8", "irq global gate", rxIrq, 0);
    globalIntEn = 1'b1; rxIntEn = 1'b0; #1;
    check("R8", "irq local gate", rxIrq, 0);
    rxIntEn = 1'b1;
    readChar();
    check("R6", "read clears", rxComplete, 0);
    check("R8", "irq off", rxIrq, 0);

    // R2 reserved size code behaves as 8 bits
    charSize = 3'b101;
    sendAsync(9'h1C3, 8, 2'b00, 0, 0, -1, -1);
    expectChar(9'h1C3, 8, 0, 0);
    readChar();

    // R3 reserved parity code sends no parity bit
    charSize = 3'b011; parityMode = 2'b01;
    sendAsync(9'h05A, 8, 2'b01, 0, 0, -1, -1);
    expectChar(9'h05A, 8, 0, 0);
    readChar();

    // random async frames: R1 R2 R3 R4 R10
    for (int k = 0; k < 20; k++) begin
      logic [2:0] code = codes[$urandom % 5];
      int n = sizeOf(code);
      logic [1:0] pm = 2'($urandom % 4);
      logic [8:0] d = 9'($urandom);
      bit bp = pm[1] && ($urandom % 4 == 0);
      bit bs = ($urandom % 5 == 0);
      int g = ($urandom % 3 == 0) ? int'($urandom % n) : -1;
      charSize = code; parityMode = pm;
      sendAsync(d, n, pm, bp, bs, g, -1);
      expectChar(d, n, bp, bs);
      readChar();
      check("R6", "cleared after read", rxComplete, 0);
    end

    // R10 one-tick low pulse must not start a frame
    charSize = 3'b011; parityMode = 2'b00;
    @(negedge clk) serialIn = 1'b0;
    repeat (TICK_DIV) @(negedge clk);
    serialIn = 1'b1;
    repeat (3*BIT_CLKS) @(negedge clk);
    check("R10", "false start ignored", rxComplete, 0);

    // R5 overrun: second character dropped
    sendAsync(9'h011, 8, 2'b00, 0, 0, -1, -1);
    sendAsync(9'h0EE, 8, 2'b00, 0, 0, -1, -1);
    check("R5", "overrun set", overrunErr, 1);
    check("R5", "data kept", rxData, 8'h11);
    check("R5", "still complete", rxComplete, 1);
    readChar();
    check("R6", "overrun cleared", overrunErr, 0);

    // R6 read swept across the completion cycle
    for (int off = 28; off < 54; off++) begin
      sendAsync(9'h033, 8, 2'b00, 0, 0, -1, -1);
      sendAsync(9'h0CC, 8, 2'b00, 0, 0, -1, off);
      check("R6", "no overrun at read offset", overrunErr, 0);
      if (rxComplete && rxData == 8'hCC) seenNew++;
      else if (!rxComplete && rxData == 8'h33) seenOld++;
      else check("R6", "sweep outcome", {rxComplete, rxData}, 9'h1CC);
      if (rxComplete) readChar();
    end
    check("R6", "sweep saw new", seenNew > 0, 1);
    check("R6", "sweep saw old", seenOld > 0, 1);

    // R7 flush on disable, and line ignored while disabled
    parityMode = 2'b10;
    sendAsync(9'h00F, 8, 2'b10, 1, 1, -1, -1);
    sendAsync(9'h0F0, 8, 2'b10, 0, 0, -1, -1);
    check("R7", "setup flags", {rxComplete, frameErr, overrunErr, parityErr}, 4'hF);
    @(negedge clk) rxEnable = 1'b0;
    @(negedge clk);
    check("R7", "flushed flags", {rxComplete, frameErr, overrunErr, parityErr, rxBit8}, 0);
    check("R7", "flushed data", rxData, 0);
    sendAsync(9'h081, 8, 2'b10, 0, 0, -1, -1);
    check("R7", "ignored while off", rxComplete, 0);
    rxEnable = 1'b1; parityMode = 2'b00;
    repeat (BIT_CLKS) @(negedge clk);

    // R9 synchronous mode, both polarities
    syncMode = 1'b1; clkPolarity = 1'b0; extClk = 1'b0;
    repeat (8) @(negedge clk);
    sendSync(9'h03C, 8, 2'b00, 0, 0);
    check("R9", "pol0 complete", rxComplete, 1);
    check("R9", "pol0 data", rxData, 8'h3C);
    readChar();
    charSize = 3'b111; parityMode = 2'b11;
    sendSync(9'h1A5, 9, 2'b11, 0, 0);
    check("R9", "pol0 9-bit data", rxData, 8'hA5);
    check("R9", "pol0 bit8", rxBit8, 1);
    check("R9", "pol0 parity ok", parityErr, 0);
    readChar();
    clkPolarity = 1'b1; extClk = 1'b1;
    repeat (8) @(negedge clk);
    charSize = 3'b000; parityMode = 2'b10;
    sendSync(9'h016, 5, 2'b10, 1, 0);
    check("R9", "pol1 data", rxData, 8'h16);
    check("R9", "pol1 parity err", parityErr, 1);
    readChar();
    for (int k = 0; k < 4; k++) begin
      logic [8:0] d = 9'($urandom);
      charSize = 3'b011; parityMode = 2'b11;
      sendSync(d, 8, 2'b11, 0, k == 2);
      check("R9", "pol1 random data", rxData, d[7:0]);
      check("R4", "sync frame err", frameErr, k == 2);
      readChar();
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule